// File: doc/BRIEF.md
# Stream-to-RAM Single-Port Bridge

This block lets a producer and a consumer that speak valid/ready streams drive a single-port read/write RAM whose read data returns after a fixed number of cycles and which has no handshake of its own. Each request carries an address, write data, a write enable and a read enable. The RAM enables pulse only in the cycle a request is taken. Read data that comes back from the RAM is caught in a small in-order buffer and offered on the response stream.

A credit counter tracks every read that has been accepted but whose response the consumer has not yet taken. The request stream is held off while that count equals the buffer depth. As a result, read data never arrives at a full buffer, even when the consumer stalls for a long time. Write-only requests use no credit and produce no response.

Top module: `ram_stream_bridge`

## Requirements
- R1: After reset, with no request offered, `req_ready` is 1, `rsp_valid` is 0, and `ram_we` and `ram_re` are 0.
- R2: In every cycle, `ram_re` equals `req_valid & req_ready & req_re` and `ram_we` equals `req_valid & req_ready & req_we`. In a cycle where a request is taken, `ram_addr` and `ram_wdata` carry that request's address and write data.
- R3: With the consumer ready and no backlog, a read taken in cycle t first shows `rsp_valid` in cycle t+LATENCY+1. The RAM is expected to present read data on `ram_rdata` LATENCY cycles after `ram_re`.
- R4: A request with `req_re` = 0 never produces a response, even when `req_we` = 1.
- R5: Responses leave in the same order as their read requests were taken, each carrying the word the RAM returned for that read.
- R6: While `rsp_valid` is 1 and `rsp_ready` is 0, the next cycle still has `rsp_valid` = 1 with `rsp_rdata` unchanged.
- R7: `req_ready` is 0 exactly when the number of taken reads not yet delivered on the response stream equals DEPTH. After any delivery from a full state, `req_ready` is 1 in the following cycle.
- R8: A request with both enables set, used with a RAM that reads before it writes, returns the address's previous contents. A later read of that address returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_we | input | 1 | Request write enable |
| req_re | input | 1 | Request read enable |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_rdata | output | DATA_W | Response read data |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_rdata | input | DATA_W | RAM read data, valid LATENCY cycles after `ram_re` |

## Verification
The bench builds the bridge with LATENCY = 2, DEPTH = 3, a 4-bit address and 8-bit data. The two-cycle latency exercises the multi-stage tracker branch, where more than one read is in the RAM pipeline at once. The depth of 3 is small enough that a stalled consumer fills the credit window within a few requests, so the full-window stall and its release are reached quickly. The small address space makes it easy to revisit addresses, which is needed to observe combined read-and-write requests.

// File: rtl/ram_bridge_pkg.sv
package ram_bridge_pkg;

    // Strobes sent to the RAM for one request slot
    typedef struct packed {
        logic wr;
        logic rd;
    } ram_op_t;

    function automatic ram_op_t op_for(input logic take, input logic we, input logic re);
        ram_op_t o;
        o.wr = take & we;
        o.rd = take & re;
        return o;
    endfunction

endpackage

// File: rtl/ram_bridge_track.sv
// Shifts a flag for each issued read; land_o rises in the cycle its data is on the RAM bus.
module ram_bridge_track #(
    parameter int unsigned LATENCY = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic issue_i,
    output logic land_o
);
    logic [LATENCY-1:0] stage_d, stage_q;

    generate
        if (LATENCY == 1) begin : g_single
            always_comb stage_d = issue_i;
        end else begin : g_multi
            always_comb stage_d = {stage_q[LATENCY-2:0], issue_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    assign land_o = stage_q[LATENCY-1];

endmodule

// File: rtl/ram_bridge_catch.sv
// In-order buffer for read data returning from the RAM.
module ram_bridge_catch #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic take;
    assign take = pop_i && (ctl_q.cnt != '0);

    always_comb begin
        ctl_d = ctl_q;
        if (push_i) ctl_d.wr = bump(ctl_q.wr);
        if (take)   ctl_d.rd = bump(ctl_q.rd);
        ctl_d.cnt = ctl_q.cnt + CNT_W'(push_i) - CNT_W'(take);
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem_q[ctl_q.wr] <= push_data_i;
    end

    assign valid_o = (ctl_q.cnt != '0);
    assign data_o  = mem_q[ctl_q.rd];

    // Credit gating upstream must keep returning data from meeting a full buffer
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        push_i |-> (ctl_q.cnt < CNT_W'(DEPTH)))
        else $error("catch buffer written while full");

endmodule

// File: rtl/ram_stream_bridge.sv
module ram_stream_bridge
    import ram_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned LATENCY = 1,
    parameter int unsigned DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_we,
    input  logic              req_re,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              ram_re,
    input  logic [DATA_W-1:0] ram_rdata
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CNT_W-1:0] used;
    } state_t;

    state_t  st_d, st_q;
    ram_op_t op;
    logic    take_req, take_rsp, landed;

    assign req_ready = (st_q.used < CNT_W'(DEPTH));
    assign take_req  = req_valid && req_ready;
    assign take_rsp  = rsp_valid && rsp_ready;
    assign op        = op_for(take_req, req_we, req_re);

    always_comb begin
        st_d      = st_q;
        st_d.used = st_q.used + CNT_W'(op.rd) - CNT_W'(take_rsp);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ram_addr  = req_addr;
    assign ram_wdata = req_wdata;
    assign ram_we    = op.wr;
    assign ram_re    = op.rd;

    ram_bridge_track #(.LATENCY(LATENCY)) u_track (
        .clk     (clk),
        .rst     (rst),
        .issue_i (op.rd),
        .land_o  (landed)
    );

    ram_bridge_catch #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_catch (
        .clk         (clk),
        .rst         (rst),
        .push_i      (landed),
        .push_data_i (ram_rdata),
        .pop_i       (take_rsp),
        .valid_o     (rsp_valid),
        .data_o      (rsp_rdata)
    );

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rsp_valid && req_ready))
        else $error("not idle after reset");

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)))
        else $error("stalled response changed");

    p_rsp_has_credit_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (st_q.used != '0))
        else $error("response without an owning read");

    p_land_has_credit_r4: assert property (@(posedge clk) disable iff (rst)
        landed |-> (st_q.used != '0))
        else $error("returned data without an issued read");

    p_full_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !take_rsp) |=> !req_ready)
        else $error("ready rose without a delivery");

endmodule

// File: tb/ram_stream_bridge_tb.sv
module ram_stream_bridge_tb;
    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int LAT = 2;
    localparam int DEP = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0, req_re = 1'b0, rsp_ready = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, ram_we, ram_re;
    logic [DW-1:0] rsp_rdata, ram_wdata, ram_rdata;
    logic [AW-1:0] ram_addr;

    always #4 clk = ~clk;

    ram_stream_bridge #(.ADDR_W(AW), .DATA_W(DW), .LATENCY(LAT), .DEPTH(DEP)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_we(req_we), .req_re(req_re),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .ram_re(ram_re), .ram_rdata(ram_rdata)
    );

    // RAM model: read-before-write, data on the bus LAT cycles after the read strobe
    logic [DW-1:0] ram_mem [1<<AW];
    logic [DW-1:0] rd_pipe [LAT];
    initial for (int i = 0; i < (1<<AW); i++) ram_mem[i] = '0;
    initial for (int i = 0; i < LAT; i++) rd_pipe[i] = '0;
    always @(posedge clk) begin
        if (ram_we) ram_mem[ram_addr] <= ram_wdata;
        rd_pipe[0] <= ram_re ? ram_mem[ram_addr] : '0;
        for (int i = 1; i < LAT; i++) rd_pipe[i] <= rd_pipe[i-1];
    end
    assign ram_rdata = rd_pipe[LAT-1];

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference state kept by the bench
    logic [DW-1:0] ref_mem [1<<AW];
    initial for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] got_q [$];
    int   reserved = 0;
    logic last_acc = 0, seen_valid = 0, hold_pend = 0;
    logic [DW-1:0] hold_data = '0;

    // Called right after inputs are driven at a falling edge; observes, then waits for the next
    task automatic run_cycle();
        logic acc;
        #1;
        check(req_ready == (reserved < DEP), "R7", req_ready, reserved < DEP);
        if (hold_pend)
            check(rsp_valid && rsp_rdata == hold_data, "R6", rsp_rdata, hold_data);
        acc = req_valid && req_ready;
        check(ram_re == (acc && req_re) && ram_we == (acc && req_we) &&
              (!acc || (ram_addr == req_addr && ram_wdata == req_wdata)),
              "R2", {ram_re, ram_we}, {acc && req_re, acc && req_we});
        seen_valid = rsp_valid;
        if (rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) check(1'b0, "R4 unexpected response", rsp_rdata, 0);
            else begin
                check(rsp_rdata == exp_q[0], "R5 order/data", rsp_rdata, exp_q[0]);
                void'(exp_q.pop_front());
            end
            got_q.push_back(rsp_rdata);
            reserved--;
        end
        hold_pend = rsp_valid && !rsp_ready;
        hold_data = rsp_rdata;
        if (acc) begin
            if (req_re) begin exp_q.push_back(ref_mem[req_addr]); reserved++; end
            if (req_we) ref_mem[req_addr] = req_wdata;
        end
        last_acc = acc;
        @(negedge clk);
    endtask

    task automatic drive(input logic v, input logic we, input logic re,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = v; req_we = we; req_re = re; req_addr = a; req_wdata = d;
    endtask

    task automatic send(input logic we, input logic re, input logic [AW-1:0] a, input logic [DW-1:0] d);
        drive(1'b1, we, re, a, d);
        for (int k = 0; k < 60; k++) begin
            run_cycle();
            if (last_acc) break;
        end
        drive(1'b0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic drain();
        rsp_ready = 1'b1;
        drive(1'b0, 1'b0, 1'b0, '0, '0);
        for (int k = 0; k < 20; k++) run_cycle();
        check(exp_q.size() == 0, "R5 drained", exp_q.size(), 0);
    endtask

    typedef struct packed {
        logic          we;
        logic          re;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 4'h1, 8'h11}, '{1'b1, 1'b0, 4'h2, 8'h22},
        '{1'b0, 1'b1, 4'h1, 8'h00}, '{1'b0, 1'b1, 4'h2, 8'h00},
        '{1'b1, 1'b1, 4'h1, 8'h91}, '{1'b0, 1'b1, 4'h1, 8'h00},
        '{1'b0, 1'b1, 4'h7, 8'h00}, '{1'b1, 1'b0, 4'h7, 8'h77},
        '{1'b0, 1'b1, 4'h7, 8'h00}, '{1'b0, 1'b1, 4'h2, 8'h00},
        '{1'b1, 1'b0, 4'hF, 8'hF0}, '{1'b0, 1'b1, 4'hF, 8'h00},
        '{1'b0, 1'b1, 4'h1, 8'h00}, '{1'b0, 1'b0, 4'h3, 8'h00}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        check(!ram_re && !ram_we, "R1 strobes", {ram_re, ram_we}, 0);
        @(negedge clk);

        // Table walk with a periodic consumer stall (R2, R5, R6, R7)
        for (int i = 0; i < NV; i++) begin
            rsp_ready = (cyc % 4) != 1;
            send(VEC[i].we, VEC[i].re, VEC[i].addr, VEC[i].wdata);
        end
        drain();

        // R3: latency from acceptance to first valid response
        rsp_ready = 1'b1;
        drive(1'b1, 1'b0, 1'b1, 4'h2, 8'h00);
        run_cycle();
        check(last_acc, "R3 accept", last_acc, 1);
        drive(1'b0, 1'b0, 1'b0, '0, '0);
        for (int k = 1; k <= LAT + 1; k++) begin
            run_cycle();
            check(seen_valid == (k == LAT + 1), "R3 timing", seen_valid, k == LAT + 1);
        end
        drain();

        // R4: write-only traffic yields no responses
        begin
            logic any = 0;
            for (int k = 0; k < 4; k++) begin
                send(1'b1, 1'b0, AW'(k + 8), DW'(8'hA0 + k));
                any |= seen_valid;
            end
            for (int k = 0; k < 6; k++) begin run_cycle(); any |= seen_valid; end
            check(!any, "R4 no response", any, 0);
        end

        // R7: stalled consumer fills the credit window
        begin
            int taken = 0;
            rsp_ready = 1'b0;
            drive(1'b1, 1'b0, 1'b1, 4'h8, 8'h00);
            for (int k = 0; k < 10; k++) begin
                run_cycle();
                if (last_acc) taken++;
            end
            check(taken == DEP, "R7 window", taken, DEP);
            check(!req_ready, "R7 blocked", req_ready, 0);
            drive(1'b0, 1'b0, 1'b0, '0, '0);
            rsp_ready = 1'b1;
            run_cycle();
            rsp_ready = 1'b0;
            #1;
            check(req_ready, "R7 released", req_ready, 1);
            @(negedge clk);
        end
        drain();

        // R8: combined read and write returns the old word, then the new one
        send(1'b1, 1'b0, 4'h5, 8'h55);
        got_q.delete();
        rsp_ready = 1'b1;
        send(1'b1, 1'b1, 4'h5, 8'hAA);
        send(1'b0, 1'b1, 4'h5, 8'h00);
        drain();
        check(got_q.size() == 2, "R8 count", got_q.size(), 2);
        if (got_q.size() == 2) begin
            check(got_q[0] == 8'h55, "R8 old word", got_q[0], 8'h55);
            check(got_q[1] == 8'hAA, "R8 new word", got_q[1], 8'hAA);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R5 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule